// File: doc/BRIEF.md
# DDC Target Controller

This block is a target-only I2C controller for a display data channel. It listens on the two-wire bus and answers two device addresses. One address serves an identification image. That image sits in a local single-port byte RAM, and the initiator can both write it and read it back. The other address turns each bus transfer into a read or write strobe on a register port of the receiver core.

An initiator first writes a one-byte offset, which sets the internal pointer. It then either keeps writing bytes at that pointer, or it issues a repeated START and reads from it. The pointer advances after every data byte and wraps around at the top of the space. The line inputs pass through synchronisers. The block never drives the data line high: it only pulls it low through an output enable.

Top module: `ddc_target`

## Requirements
- R1: An address byte whose upper seven bits equal `ID_DEV` (default 0x50, so bytes 0xA0/0xA1) is acknowledged and selects the RAM-backed identification space.
- R2: Bit 0 of the address byte selects the direction: 1 starts a read transfer, 0 starts a write transfer.
- R3: An address byte whose upper seven bits equal `REG_DEV` (default 0x54, so bytes 0xA8/0xA9) selects the register space. A written data byte produces a one-cycle `reg_wr` pulse with `reg_addr` equal to the pointer. A read byte is fetched with a one-cycle `reg_rd` pulse, and `reg_rdata` must be valid from the following cycle until the next pulse. No two of the RAM write, `reg_wr` and `reg_rd` strobes are ever high together.
- R4: With `REG_EN` = 0, register-space addresses are not acknowledged and `reg_wr`/`reg_rd` never pulse.
- R5: The first data byte of a write transfer loads the pointer. Every later byte is stored at the pointer, and the pointer then increments.
- R6: A read transfer starts at the current pointer, whether that pointer was set in the same transaction or left by an earlier one. The pointer increments after each byte and wraps from 255 to 0.
- R7: The target pulls SDA low in the acknowledge bit of a matched address and of every written byte. During reads it releases SDA for the acknowledge bit. A NACK from the initiator ends the read, and SDA stays released until the next START.
- R8: An address byte that matches neither space gets no acknowledge. The block ignores the bus until the next START and then serves transfers normally.
- R9: SDA falling while SCL is high is a START and restarts address reception. SDA rising while SCL is high is a STOP, which returns the block to idle with SDA released.
- R10: `sda_oe` (1 = pull SDA low) turns on only while the synchronised SCL is low.
- R11: During reset `sda_oe`, `reg_wr` and `reg_rd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| reg_addr | output | PTR_W | Register-port byte address |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, valid the cycle after `reg_rd` |

## Verification
Some properties are checked on every cycle: the acknowledge and data drive starts only while SCL is low, SDA is released after each STOP, the three strobes are mutually exclusive single-cycle pulses, and with the register space disabled the register port stays silent. Other behaviour only shows up across whole transactions, so only the bench scenarios can demonstrate it. This covers pointer loading and wrap-around, reads that continue from a pointer left by an earlier transaction, NACK handling, recovery after a foreign address, and data round trips through both the RAM and the register port.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WBYTE,
    ST_WACK,
    ST_RBYTE,
    ST_RACK
  } ddc_state_t;

  typedef enum logic {
    SP_ID,
    SP_REG
  } ddc_space_t;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/ddc_sync.sv
module ddc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/ddc_ram.sv
module ddc_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int unsigned DEPTH = 2 ** AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/ddc_addr_match.sv
module ddc_addr_match
  import ddc_pkg::*;
#(
  parameter logic [6:0] ID_DEV  = 7'h50,
  parameter logic [6:0] REG_DEV = 7'h54,
  parameter bit         REG_EN  = 1'b1
) (
  input  logic [7:0]  abyte,
  output logic        hit,
  output ddc_space_t  space,
  output logic        rd
);
  logic id_hit, reg_hit;

  assign id_hit = (abyte[7:1] == ID_DEV);

  generate
    if (REG_EN) begin : g_reg_on
      assign reg_hit = (abyte[7:1] == REG_DEV);
    end else begin : g_reg_off
      assign reg_hit = 1'b0;
    end
  endgenerate

  assign hit   = id_hit | reg_hit;
  assign space = id_hit ? SP_ID : SP_REG;
  assign rd    = abyte[0];
endmodule

// File: rtl/ddc_target.sv
module ddc_target
  import ddc_pkg::*;
#(
  parameter logic [6:0]  ID_DEV      = 7'h50,
  parameter logic [6:0]  REG_DEV     = 7'h54,
  parameter bit          REG_EN      = 1'b1,
  parameter int unsigned PTR_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [PTR_W-1:0]  reg_addr,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic [BYTE_W-1:0] reg_rdata
);
  localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);
  localparam logic [3:0]       BITS_END = 4'(BYTE_W);
  localparam logic [3:0]       LAST_BIT = 4'(BYTE_W - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  ddc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  ddc_state_t        state;
  ddc_space_t        space;
  logic              rw, first, seen, mack;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] sr;
  logic [PTR_W-1:0]  ptr;

  logic              hit, hit_rd;
  ddc_space_t        hit_space;

  ddc_addr_match #(.ID_DEV(ID_DEV), .REG_DEV(REG_DEV), .REG_EN(REG_EN)) u_match (
    .abyte(sr), .hit(hit), .space(hit_space), .rd(hit_rd)
  );

  logic              ram_we;
  logic [PTR_W-1:0]  wr_addr, ram_addr;
  logic [BYTE_W-1:0] wr_data, ram_q, rd_byte;

  assign ram_addr = ram_we ? wr_addr : ptr;

  ddc_ram #(.AW(PTR_W), .DW(BYTE_W)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(wr_data), .q(ram_q)
  );

  assign rd_byte = (space == SP_REG) ? reg_rdata : ram_q;

  logic reg_en_c;
  assign reg_en_c = REG_EN;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      space     <= SP_ID;
      rw        <= 1'b0;
      first     <= 1'b0;
      seen      <= 1'b0;
      mack      <= 1'b0;
      cnt       <= '0;
      sr        <= '0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
      ram_we    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      ram_we <= 1'b0;
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              sr  <= {sr[BYTE_W-2:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == BITS_END) begin
              if (hit) begin
                sda_oe <= 1'b1;
                space  <= hit_space;
                rw     <= hit_rd;
                seen   <= 1'b0;
                state  <= ST_AACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_rise) begin
              seen <= 1'b1;
              if (rw && space == SP_REG) begin
                reg_rd   <= 1'b1;
                reg_addr <= ptr;
              end
            end else if (scl_fall && seen) begin
              cnt  <= '0;
              seen <= 1'b0;
              if (rw) begin
                sr     <= rd_byte;
                sda_oe <= ~rd_byte[BYTE_W-1];
                ptr    <= ptr + PTR_ONE;
                state  <= ST_RBYTE;
              end else begin
                sda_oe <= 1'b0;
                first  <= 1'b1;
                state  <= ST_WBYTE;
              end
            end
          end
          ST_WBYTE: begin
            if (scl_rise) begin
              sr  <= {sr[BYTE_W-2:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == BITS_END) begin
              sda_oe <= 1'b1;
              seen   <= 1'b0;
              state  <= ST_WACK;
              if (first) begin
                ptr   <= sr[PTR_W-1:0];
                first <= 1'b0;
              end else begin
                if (space == SP_REG) begin
                  reg_wr    <= 1'b1;
                  reg_addr  <= ptr;
                  reg_wdata <= sr;
                end else begin
                  ram_we  <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= sr;
                end
                ptr <= ptr + PTR_ONE;
              end
            end
          end
          ST_WACK: begin
            if (scl_rise) begin
              seen <= 1'b1;
            end else if (scl_fall && seen) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              seen   <= 1'b0;
              state  <= ST_WBYTE;
            end
          end
          ST_RBYTE: begin
            if (scl_fall) begin
              if (cnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                seen   <= 1'b0;
                state  <= ST_RACK;
              end else begin
                sr     <= {sr[BYTE_W-2:0], 1'b0};
                sda_oe <= ~sr[BYTE_W-2];
                cnt    <= cnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              seen <= 1'b1;
              mack <= ~sda_s;
              if (!sda_s && space == SP_REG) begin
                reg_rd   <= 1'b1;
                reg_addr <= ptr;
              end
            end else if (scl_fall && seen) begin
              seen <= 1'b0;
              cnt  <= '0;
              if (mack) begin
                sr     <= rd_byte;
                sda_oe <= ~rd_byte[BYTE_W-1];
                ptr    <= ptr + PTR_ONE;
                state  <= ST_RBYTE;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ddc_target_chk.sv
module ddc_target_chk (
  input logic clk,
  input logic rst,
  input logic scl_s,
  input logic stop_det,
  input logic sda_oe,
  input logic ram_we,
  input logic reg_wr,
  input logic reg_rd,
  input logic reg_en
);
  // R10: pulling SDA low starts only in an SCL low phase
  a_r10_drive_in_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(scl_s));

  // R9: a STOP leaves SDA released
  a_r9_stop_release: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R3: strobes never overlap
  a_r3_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_we, reg_wr, reg_rd}));

  // R3: a register write strobe lasts one cycle
  a_r3_wr_pulse: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> !reg_wr);

  // R3: a register read strobe lasts one cycle
  a_r3_rd_pulse: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> !reg_rd);

  // R4: no register traffic when the space is disabled
  a_r4_silent_off: assert property (@(posedge clk) disable iff (rst)
    (reg_wr || reg_rd) |-> reg_en);
endmodule

bind ddc_target ddc_target_chk u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .stop_det(stop_det), .sda_oe(sda_oe),
  .ram_we(ram_we), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_en(reg_en_c)
);

// File: tb/ddc_target_bench.sv
`timescale 1ns/1ps
module ddc_target_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic oe_a, oe_b;
  logic sda_line;
  assign sda_line = m_sda & ~oe_a & ~oe_b;

  logic [7:0] reg_addr_a, reg_wdata_a, reg_addr_b, reg_wdata_b;
  logic [7:0] reg_rdata_a;
  logic       reg_wr_a, reg_rd_a, reg_wr_b, reg_rd_b;
  logic [7:0] regmem [256];

  always #2.5 clk = ~clk;

  ddc_target #(.ID_DEV(7'h50), .REG_DEV(7'h54), .REG_EN(1'b1)) u_ddc_target (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(oe_a),
    .reg_addr(reg_addr_a), .reg_wr(reg_wr_a), .reg_rd(reg_rd_a),
    .reg_wdata(reg_wdata_a), .reg_rdata(reg_rdata_a)
  );

  ddc_target #(.ID_DEV(7'h51), .REG_DEV(7'h54), .REG_EN(1'b0)) u_ddc_target_noreg (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(oe_b),
    .reg_addr(reg_addr_b), .reg_wr(reg_wr_b), .reg_rd(reg_rd_b),
    .reg_wdata(reg_wdata_b), .reg_rdata(8'h00)
  );

  // register-port model of the receiver core
  always @(posedge clk) begin
    if (reg_wr_a) regmem[reg_addr_a] <= reg_wdata_a;
    if (reg_rd_a) reg_rdata_a <= regmem[reg_addr_a];
  end

  int n_chk = 0, n_fail = 0, n_wr = 0, n_rd = 0, n_b = 0, n_viol = 0;
  bit done = 1'b0, reported = 1'b0;
  logic prev_oe = 1'b0;

  always @(posedge clk) begin
    if (!rst) begin
      if (reg_wr_a) n_wr++;
      if (reg_rd_a) n_rd++;
      if (reg_wr_b || reg_rd_b || oe_b) n_b++;
      if (oe_a !== prev_oe && m_scl) n_viol++;
    end
    prev_oe <= oe_a;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic wq();
    repeat (10) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
    m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
    end
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
    ack = ~sda_line;
    wq(); m_scl = 1'b0; wq();
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic nack);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); m_scl = 1'b1; wq();
      b[i] = sda_line;
      wq(); m_scl = 1'b0; wq();
    end
    m_sda = nack; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
    m_sda = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      report();
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    check("R11 sda_oe in reset", int'(oe_a), 0);
    check("R11 reg_wr in reset", int'(reg_wr_a), 0);
    check("R11 reg_rd in reset", int'(reg_rd_a), 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);

    // R1 R5 R7: write 16 bytes starting at 0xF8, wrapping past 0xFF
    i2c_start();
    send_byte(8'hA0, ack); check("R1 ack of 0xA0", int'(ack), 1);
    send_byte(8'hF8, ack); check("R5 ack of offset", int'(ack), 1);
    for (int i = 0; i < 16; i++) begin
      send_byte(pat((248 + i) & 255), ack);
      check("R7 ack of written byte", int'(ack), 1);
    end
    i2c_stop();
    check("R9 released after stop", int'(oe_a), 0);

    // R2 R6: set pointer, repeated start, read 8 bytes, NACK on last
    i2c_start();
    send_byte(8'hA0, ack);
    send_byte(8'hF8, ack);
    i2c_start();
    send_byte(8'hA1, ack); check("R2 ack of read address", int'(ack), 1);
    for (int i = 0; i < 8; i++) begin
      recv_byte(d, i == 7);
      check("R6 read data from offset", int'(d), int'(pat(248 + i)));
    end
    check("R7 released after NACK", int'(oe_a), 0);
    recv_byte(d, 1'b1);
    check("R7 no data after NACK", int'(d), 8'hFF);
    i2c_stop();

    // R6: read continues from the wrapped pointer left at 0x00
    i2c_start();
    send_byte(8'hA1, ack); check("R2 ack of bare read", int'(ack), 1);
    for (int i = 0; i < 8; i++) begin
      recv_byte(d, i == 7);
      check("R6 read after wrap", int'(d), int'(pat(i)));
    end
    i2c_stop();

    // R3: register-space write of three bytes at 0x40
    i2c_start();
    send_byte(8'hA8, ack); check("R3 ack of 0xA8", int'(ack), 1);
    send_byte(8'h40, ack);
    send_byte(8'h5A, ack); send_byte(8'hC3, ack); send_byte(8'h81, ack);
    check("R3 ack of reg byte", int'(ack), 1);
    i2c_stop();
    check("R3 reg_wr count", n_wr, 3);
    check("R3 reg 0x40", int'(regmem[8'h40]), 8'h5A);
    check("R3 reg 0x41", int'(regmem[8'h41]), 8'hC3);
    check("R3 reg 0x42", int'(regmem[8'h42]), 8'h81);

    // R3: register-space read back
    i2c_start();
    send_byte(8'hA8, ack);
    send_byte(8'h40, ack);
    i2c_start();
    send_byte(8'hA9, ack); check("R3 ack of 0xA9", int'(ack), 1);
    recv_byte(d, 1'b0); check("R3 reg read 0", int'(d), 8'h5A);
    recv_byte(d, 1'b0); check("R3 reg read 1", int'(d), 8'hC3);
    recv_byte(d, 1'b1); check("R3 reg read 2", int'(d), 8'h81);
    i2c_stop();
    check("R3 reg_rd count", n_rd, 3);

    // R8: foreign address gets no ACK and the following byte is ignored
    i2c_start();
    send_byte(8'hB0, ack); check("R8 no ack of 0xB0", int'(ack), 0);
    send_byte(8'h00, ack); check("R8 byte ignored", int'(ack), 0);
    i2c_stop();
    check("R8 no reg writes", n_wr, 3);

    // R8 R1: normal service resumes after the foreign address
    i2c_start();
    send_byte(8'hA0, ack); check("R8 ack after recovery", int'(ack), 1);
    send_byte(8'h03, ack);
    i2c_start();
    send_byte(8'hA1, ack);
    recv_byte(d, 1'b1); check("R1 RAM data at 0x03", int'(d), int'(pat(3)));
    i2c_stop();

    // R4: instance with register space off stayed silent throughout
    check("R4 disabled instance activity", n_b, 0);
    // R10: SDA drive never changed while SCL was high
    check("R10 drive changes in SCL high", n_viol, 0);

    done = 1'b1;
    report();
    $finish;
  end
endmodule